// File: doc/BRIEF.md
# Interrupt and Break Entry Sequencer

This block runs the bus cycles that move an 8-bit processor into an exception handler. A hardware interrupt (maskable or non-maskable) or the software break instruction starts it. It saves the return address and a packed status byte on a stack that always sits in page one of memory. It sets the interrupt-disable flag and then loads the program counter from the vector pair that belongs to the source. On each start it takes a snapshot of the program counter, stack pointer and flag bits. It hands back the updated program counter, stack pointer and interrupt-disable flag, and it drives one cycle per bus transfer on a byte-wide read/write bus.

Deciding which hardware interrupt wins is left to the caller, and so is opcode decoding. There is one exception. When a break is pushing its status and a non-maskable interrupt is pending, the sequencer acknowledges and consumes that interrupt, and the vector fetch then goes to the non-maskable vector.

Top module: `ient_entry_seq`

## Requirements
- R1: After a synchronous reset (rst_n low on a clock edge) busy_o, done_o, bus_we_o, bus_rd_o, nmi_ack_o, iflag_o, pc_o and sp_o are all zero.
- R2: A start with src_i = 2'b00 (maskable) or 2'b01 (non-maskable) produces seven bus cycles. The first two are reads at the captured program counter, which stays unchanged. Three stack writes follow, then two vector reads. src_i = 2'b11 behaves as 2'b00. The bus never reads and writes in the same cycle.
- R3: A start with src_i = 2'b10 (break) produces one read at the captured program counter and then increments it. The pushed return address is therefore the captured value plus one. The sequence is six bus cycles long.
- R4: Every stack write goes to address {8'h01, sp}, and the stack pointer is decremented after the write. The writes carry the return address high byte, then its low byte, then the status byte. sp_o ends three below its captured value, modulo 256.
- R5: The status byte has N in bit 7, V in bit 6, a constant 1 in bit 5, the break bit in bit 4, D in bit 3, I in bit 2, Z in bit 1 and C in bit 0. All flags are taken as captured at start.
- R6: The break bit (bit 4) is 1 only for a break start, and 0 for either hardware interrupt.
- R7: iflag_o keeps the captured I value up to and including the status write cycle. It reads 1 from the next cycle on.
- R8: A maskable interrupt or a break reads the vector low byte at 16'hFFFE and then the high byte at 16'hFFFF. A non-maskable interrupt uses 16'hFFFA and then 16'hFFFB. The program counter is loaded as {high, low}.
- R9: If nmi_pend_i is high during a break's status write cycle, nmi_ack_o pulses in that cycle and the vector reads use 16'hFFFA/16'hFFFB. In a hardware interrupt sequence nmi_pend_i is ignored and nmi_ack_o stays low.
- R10: done_o is high for exactly one cycle, right after the high vector byte is read. In that cycle busy_o is low and pc_o, sp_o and iflag_o hold their final values. The cycle count from the start cycle to done_o is 8 for a hardware interrupt and 7 for a break.
- R11: A start_i that arrives while busy_o is high is ignored. The running sequence goes on unchanged, and no further sequence follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request to begin an entry sequence (taken only when idle) |
| src_i | input | 2 | Source: 00 maskable, 01 non-maskable, 10 break, 11 as 00 |
| pc_i | input | 16 | Program counter to save |
| sp_i | input | 8 | Stack pointer at start |
| flag_n_i | input | 1 | Negative flag |
| flag_v_i | input | 1 | Overflow flag |
| flag_d_i | input | 1 | Decimal flag |
| flag_i_i | input | 1 | Interrupt-disable flag |
| flag_z_i | input | 1 | Zero flag |
| flag_c_i | input | 1 | Carry flag |
| nmi_pend_i | input | 1 | A non-maskable interrupt is pending |
| bus_rdata_i | input | 8 | Read data for the current bus cycle |
| bus_addr_o | output | 16 | Bus address |
| bus_wdata_o | output | 8 | Bus write data |
| bus_we_o | output | 1 | Write cycle |
| bus_rd_o | output | 1 | Read cycle |
| nmi_ack_o | output | 1 | Pending non-maskable interrupt consumed by a break |
| pc_o | output | 16 | Updated program counter |
| sp_o | output | 8 | Updated stack pointer |
| iflag_o | output | 1 | Updated interrupt-disable flag |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion strobe |

## Verification
The bench targets a break whose return address crosses a byte boundary, so an increment limited to the low byte would push the wrong high byte. It also starts with the stack pointer at zero, so the writes must wrap through 8'hFF. A design that forgot to clear the break bit on hardware interrupts, or that set it on both, would show the error in the status write. A hardware interrupt with nmi_pend_i held high and a break with it held high separate a design that diverts the vector from one that ignores the pending request or diverts every source. A start pulse in the middle of a sequence shows whether a design restarts, recaptures its inputs or queues a second run.

// File: rtl/ient_pkg.sv
// Shared types and fixed widths for the interrupt entry sequencer.
// Assumes an 8-bit data bus and a 16-bit address, with the address twice the data width.
package ient_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 16;

    // One value per bus cycle of the entry microsequence; ST_IDLE means no bus use
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_PAD0    = 3'd1,
        ST_PAD1    = 3'd2,
        ST_PUSH_HI = 3'd3,
        ST_PUSH_LO = 3'd4,
        ST_PUSH_ST = 3'd5,
        ST_VEC_LO  = 3'd6,
        ST_VEC_HI  = 3'd7
    } ient_step_e;

    // Source encodings seen on src_i
    typedef enum logic [1:0] {
        SRC_IRQ = 2'b00,
        SRC_NMI = 2'b01,
        SRC_BRK = 2'b10,
        SRC_RSV = 2'b11
    } ient_src_e;

    // Snapshot of the processor flags
    typedef struct packed {
        logic n;
        logic v;
        logic d;
        logic i;
        logic z;
        logic c;
    } ient_flags_t;
endpackage

// File: rtl/ient_step_ctl.sv
// Step controller: walks the entry microsequence one bus cycle per clock.
// Accepts a start only in ST_IDLE and latches the source. A break skips the
// second padding read. done_o is registered and pulses the cycle after ST_VEC_HI.
module ient_step_ctl
    import ient_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  ient_src_e  src_i,
    output ient_step_e step_o,
    output ient_src_e  src_q_o,
    output logic       accept_o,
    output logic       busy_o,
    output logic       done_o
);
    ient_step_e step_q, step_d;
    ient_src_e  src_q;
    logic       done_q;

    assign accept_o = start_i && (step_q == ST_IDLE);

    // Next-step selection for the microsequence
    always_comb begin
        step_d = step_q;
        case (step_q)
            ST_IDLE:    if (accept_o) step_d = ST_PAD0;
            ST_PAD0:    step_d = (src_q == SRC_BRK) ? ST_PUSH_HI : ST_PAD1;
            ST_PAD1:    step_d = ST_PUSH_HI;
            ST_PUSH_HI: step_d = ST_PUSH_LO;
            ST_PUSH_LO: step_d = ST_PUSH_ST;
            ST_PUSH_ST: step_d = ST_VEC_LO;
            ST_VEC_LO:  step_d = ST_VEC_HI;
            ST_VEC_HI:  step_d = ST_IDLE;
            default:    step_d = ST_IDLE;
        endcase
    end

    // Step, latched source and completion strobe registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= ST_IDLE;
            src_q  <= SRC_IRQ;
            done_q <= 1'b0;
        end else begin
            step_q <= step_d;
            done_q <= (step_q == ST_VEC_HI);
            if (accept_o)
                src_q <= (src_i == SRC_RSV) ? SRC_IRQ : src_i;
        end
    end

    assign step_o  = step_q;
    assign src_q_o = src_q;
    assign busy_o  = (step_q != ST_IDLE);
    assign done_o  = done_q;
endmodule

// File: rtl/ient_vec_sel.sv
// Vector selector: picks which vector pair the sequence fetches.
// A non-maskable start selects the non-maskable pair at once. A break switches
// to that pair when a request is pending during its status write, and
// acknowledges the request in that same cycle.
module ient_vec_sel
    import ient_pkg::*;
#(
    parameter logic [ADDR_W-1:0] IRQ_VEC = 16'hFFFE,
    parameter logic [ADDR_W-1:0] NMI_VEC = 16'hFFFA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  ient_src_e         src_i,
    input  ient_src_e         src_q_i,
    input  ient_step_e        step_i,
    input  logic              nmi_pend_i,
    output logic              nmi_ack_o,
    output logic [ADDR_W-1:0] vec_base_o
);
    logic use_nmi_q;

    assign nmi_ack_o = (step_i == ST_PUSH_ST) && (src_q_i == SRC_BRK) && nmi_pend_i;

    // Remember whether the fetch goes to the non-maskable pair
    always_ff @(posedge clk) begin
        if (!rst_n)
            use_nmi_q <= 1'b0;
        else if (accept_i)
            use_nmi_q <= (src_i == SRC_NMI);
        else if (nmi_ack_o)
            use_nmi_q <= 1'b1;
    end

    assign vec_base_o = use_nmi_q ? NMI_VEC : IRQ_VEC;
endmodule

// File: rtl/ient_status_pack.sv
// Status packer: builds the byte pushed to the stack from the captured flags.
// Bit 5 is fixed high. The break bit is driven by the caller.
module ient_status_pack
    import ient_pkg::*;
(
    input  ient_flags_t       flags_i,
    input  logic              brk_i,
    output logic [DATA_W-1:0] byte_o
);
    // Fixed bit placement of the status byte
    always_comb begin
        byte_o    = '0;
        byte_o[7] = flags_i.n;
        byte_o[6] = flags_i.v;
        byte_o[5] = 1'b1;
        byte_o[4] = brk_i;
        byte_o[3] = flags_i.d;
        byte_o[2] = flags_i.i;
        byte_o[1] = flags_i.z;
        byte_o[0] = flags_i.c;
    end
endmodule

// File: rtl/ient_regs.sv
// Register file and bus driver: holds pc, sp, the I flag and the flag snapshot.
// Drives the bus combinationally from the current step. Assumes each step lasts
// exactly one clock and that read data is valid in that same cycle.
module ient_regs
    import ient_pkg::*;
#(
    parameter logic [DATA_W-1:0] STACK_PAGE = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [DATA_W-1:0] sp_i,
    input  ient_flags_t       flags_i,
    input  ient_step_e        step_i,
    input  ient_src_e         src_q_i,
    input  logic [DATA_W-1:0] status_i,
    input  logic [ADDR_W-1:0] vec_base_i,
    input  logic [DATA_W-1:0] bus_rdata_i,
    output ient_flags_t       flags_q_o,
    output logic [ADDR_W-1:0] pc_o,
    output logic [DATA_W-1:0] sp_o,
    output logic              iflag_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    output logic              bus_we_o,
    output logic              bus_rd_o
);
    localparam int HI_LSB = ADDR_W - DATA_W;

    logic [ADDR_W-1:0] pc_q;
    logic [DATA_W-1:0] sp_q;
    logic              iflag_q;
    ient_flags_t       flags_q;
    logic              is_push;

    assign is_push = (step_i == ST_PUSH_HI) || (step_i == ST_PUSH_LO) || (step_i == ST_PUSH_ST);

    // Program counter: capture, break skip, then vector load byte by byte
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc_q <= '0;
        else if (accept_i)
            pc_q <= pc_i;
        else if (step_i == ST_PAD0 && src_q_i == SRC_BRK)
            pc_q <= pc_q + ADDR_W'(1);
        else if (step_i == ST_VEC_LO)
            pc_q[DATA_W-1:0] <= bus_rdata_i;
        else if (step_i == ST_VEC_HI)
            pc_q[ADDR_W-1:HI_LSB] <= bus_rdata_i;
    end

    // Stack pointer: capture, then post-decrement on every push
    always_ff @(posedge clk) begin
        if (!rst_n)
            sp_q <= '0;
        else if (accept_i)
            sp_q <= sp_i;
        else if (is_push)
            sp_q <= sp_q - DATA_W'(1);
    end

    // Interrupt-disable flag and flag snapshot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iflag_q <= 1'b0;
            flags_q <= '0;
        end else if (accept_i) begin
            iflag_q <= flags_i.i;
            flags_q <= flags_i;
        end else if (step_i == ST_PUSH_ST) begin
            iflag_q <= 1'b1;
        end
    end

    // Bus cycle for the current step
    always_comb begin
        bus_addr_o  = '0;
        bus_wdata_o = '0;
        bus_we_o    = 1'b0;
        bus_rd_o    = 1'b0;
        case (step_i)
            ST_PAD0, ST_PAD1: begin
                bus_addr_o = pc_q;
                bus_rd_o   = 1'b1;
            end
            ST_PUSH_HI: begin
                bus_addr_o  = {STACK_PAGE, sp_q};
                bus_wdata_o = pc_q[ADDR_W-1:HI_LSB];
                bus_we_o    = 1'b1;
            end
            ST_PUSH_LO: begin
                bus_addr_o  = {STACK_PAGE, sp_q};
                bus_wdata_o = pc_q[DATA_W-1:0];
                bus_we_o    = 1'b1;
            end
            ST_PUSH_ST: begin
                bus_addr_o  = {STACK_PAGE, sp_q};
                bus_wdata_o = status_i;
                bus_we_o    = 1'b1;
            end
            ST_VEC_LO: begin
                bus_addr_o = vec_base_i;
                bus_rd_o   = 1'b1;
            end
            ST_VEC_HI: begin
                bus_addr_o = vec_base_i + ADDR_W'(1);
                bus_rd_o   = 1'b1;
            end
            default: ;
        endcase
    end

    assign flags_q_o = flags_q;
    assign pc_o      = pc_q;
    assign sp_o      = sp_q;
    assign iflag_o   = iflag_q;
endmodule

// File: rtl/ient_entry_seq.sv
// Top level of the interrupt and break entry sequencer.
// Wires the step controller, vector selector, status packer and register/bus
// block together. Assumes the caller has already arbitrated between interrupts.
module ient_entry_seq
    import ient_pkg::*;
#(
    parameter logic [DATA_W-1:0] STACK_PAGE = 8'h01,
    parameter logic [ADDR_W-1:0] IRQ_VEC    = 16'hFFFE,
    parameter logic [ADDR_W-1:0] NMI_VEC    = 16'hFFFA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        src_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [DATA_W-1:0] sp_i,
    input  logic              flag_n_i,
    input  logic              flag_v_i,
    input  logic              flag_d_i,
    input  logic              flag_i_i,
    input  logic              flag_z_i,
    input  logic              flag_c_i,
    input  logic              nmi_pend_i,
    input  logic [DATA_W-1:0] bus_rdata_i,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    output logic              bus_we_o,
    output logic              bus_rd_o,
    output logic              nmi_ack_o,
    output logic [ADDR_W-1:0] pc_o,
    output logic [DATA_W-1:0] sp_o,
    output logic              iflag_o,
    output logic              busy_o,
    output logic              done_o
);
    ient_step_e        step;
    ient_src_e         src_q;
    ient_src_e         src_in;
    logic              accept;
    ient_flags_t       flags_in;
    ient_flags_t       flags_q;
    logic [DATA_W-1:0] status_byte;
    logic [ADDR_W-1:0] vec_base;

    assign src_in   = ient_src_e'(src_i);
    assign flags_in = '{n: flag_n_i, v: flag_v_i, d: flag_d_i,
                        i: flag_i_i, z: flag_z_i, c: flag_c_i};

    ient_step_ctl u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .src_i    (src_in),
        .step_o   (step),
        .src_q_o  (src_q),
        .accept_o (accept),
        .busy_o   (busy_o),
        .done_o   (done_o)
    );

    ient_vec_sel #(
        .IRQ_VEC (IRQ_VEC),
        .NMI_VEC (NMI_VEC)
    ) u_vec (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept_i   (accept),
        .src_i      (src_in),
        .src_q_i    (src_q),
        .step_i     (step),
        .nmi_pend_i (nmi_pend_i),
        .nmi_ack_o  (nmi_ack_o),
        .vec_base_o (vec_base)
    );

    ient_status_pack u_pack (
        .flags_i (flags_q),
        .brk_i   (src_q == SRC_BRK),
        .byte_o  (status_byte)
    );

    ient_regs #(
        .STACK_PAGE (STACK_PAGE)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept_i    (accept),
        .pc_i        (pc_i),
        .sp_i        (sp_i),
        .flags_i     (flags_in),
        .step_i      (step),
        .src_q_i     (src_q),
        .status_i    (status_byte),
        .vec_base_i  (vec_base),
        .bus_rdata_i (bus_rdata_i),
        .flags_q_o   (flags_q),
        .pc_o        (pc_o),
        .sp_o        (sp_o),
        .iflag_o     (iflag_o),
        .bus_addr_o  (bus_addr_o),
        .bus_wdata_o (bus_wdata_o),
        .bus_we_o    (bus_we_o),
        .bus_rd_o    (bus_rd_o)
    );
endmodule

// File: rtl/ient_entry_seq_chk.sv
// Property checker for the entry sequencer, attached to the top by bind.
// Looks at the top's ports and at its internal step signal.
module ient_entry_seq_chk
    import ient_pkg::*;
#(
    parameter logic [DATA_W-1:0] STACK_PAGE = 8'h01
) (
    input logic              clk,
    input logic              rst_n,
    input ient_step_e        step,
    input logic [ADDR_W-1:0] bus_addr_o,
    input logic              bus_we_o,
    input logic              bus_rd_o,
    input logic              nmi_ack_o,
    input logic [DATA_W-1:0] sp_o,
    input logic              iflag_o,
    input logic              busy_o,
    input logic              done_o
);
    // R2
    bus_mutex_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we_o && bus_rd_o));

    // R4
    stack_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we_o |-> bus_addr_o[ADDR_W-1:ADDR_W-DATA_W] == STACK_PAGE);

    // R4
    push_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we_o |=> sp_o == $past(sp_o) - 8'd1);

    // R7
    iflag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step == ST_PUSH_ST) |=> iflag_o);

    // R8
    vec_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step == ST_VEC_HI) |-> bus_addr_o == $past(bus_addr_o) + 16'd1);

    // R9
    ack_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_ack_o |-> bus_we_o && busy_o);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o && iflag_o);

    // R11
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && step != ST_VEC_HI) |=> busy_o);
endmodule

bind ient_entry_seq ient_entry_seq_chk #(.STACK_PAGE(STACK_PAGE)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .step       (step),
    .bus_addr_o (bus_addr_o),
    .bus_we_o   (bus_we_o),
    .bus_rd_o   (bus_rd_o),
    .nmi_ack_o  (nmi_ack_o),
    .sp_o       (sp_o),
    .iflag_o    (iflag_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
);

// File: tb/ient_entry_seq_bench.sv
// Scoreboard bench: the driver queues the expected bus cycles and the monitor
// compares them with what the design drives.
module ient_entry_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  src_i = 2'b00;
    logic [15:0] pc_i = '0;
    logic [7:0]  sp_i = '0;
    logic        fn = 0, fv = 0, fd = 0, fi = 0, fz = 0, fc = 0;
    logic        nmi_pend_i = 1'b0;
    logic [7:0]  bus_rdata_i;
    logic [15:0] bus_addr_o;
    logic [7:0]  bus_wdata_o;
    logic        bus_we_o, bus_rd_o, nmi_ack_o, iflag_o, busy_o, done_o;
    logic [15:0] pc_o;
    logic [7:0]  sp_o;

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;

    typedef struct {
        logic [15:0] addr;
        logic        we;
        logic [7:0]  wdata;
        logic        ack;
        logic [7:0]  sp;
        logic        ival;
        string       tag;
    } exp_item_t;

    exp_item_t exp_q[$];

    always #5 clk = ~clk;

    ient_entry_seq u_ient_entry_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .src_i(src_i),
        .pc_i(pc_i), .sp_i(sp_i),
        .flag_n_i(fn), .flag_v_i(fv), .flag_d_i(fd),
        .flag_i_i(fi), .flag_z_i(fz), .flag_c_i(fc),
        .nmi_pend_i(nmi_pend_i), .bus_rdata_i(bus_rdata_i),
        .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o),
        .bus_we_o(bus_we_o), .bus_rd_o(bus_rd_o), .nmi_ack_o(nmi_ack_o),
        .pc_o(pc_o), .sp_o(sp_o), .iflag_o(iflag_o),
        .busy_o(busy_o), .done_o(done_o)
    );

    // Memory model: fixed vector bytes, other addresses give a mix of the address
    always_comb begin
        case (bus_addr_o)
            16'hFFFE: bus_rdata_i = 8'h34;
            16'hFFFF: bus_rdata_i = 8'h12;
            16'hFFFA: bus_rdata_i = 8'h78;
            16'hFFFB: bus_rdata_i = 8'h56;
            default:  bus_rdata_i = bus_addr_o[7:0] ^ bus_addr_o[15:8];
        endcase
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Monitor: every active bus cycle must match the head of the queue
    always @(negedge clk) begin
        cyc++;
        if (rst_n && (bus_we_o || bus_rd_o)) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R11", "unexpected bus cycle", {47'd0, bus_we_o, bus_addr_o}, 64'd0);
            end else begin
                exp_item_t e;
                logic [63:0] a, x;
                e = exp_q.pop_front();
                a = {26'd0, bus_addr_o, bus_we_o, (bus_we_o ? bus_wdata_o : 8'h00),
                     nmi_ack_o, sp_o, iflag_o};
                x = {26'd0, e.addr, e.we, (e.we ? e.wdata : 8'h00), e.ack, e.sp, e.ival};
                chk(a == x, e.tag, "bus cycle {addr,we,wdata,ack,sp,i}", a, x);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        wait (cyc > 5000);
        chk(1'b0, "R10", "watchdog expired", 64'(cyc), 64'd5000);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    task automatic push_exp(input logic [15:0] a, input logic we, input logic [7:0] wd,
                            input logic ack, input logic [7:0] sp, input logic iv,
                            input string tag);
        exp_item_t e;
        e.addr = a; e.we = we; e.wdata = wd; e.ack = ack; e.sp = sp; e.ival = iv; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Driver: flags f = {n,v,d,i,z,c}; poke pulses a second start mid-sequence
    task automatic run_seq(input logic [1:0] src, input logic [15:0] pc, input logic [7:0] sp,
                           input logic [5:0] f, input logic pend, input logic poke);
        logic        brk, use_nmi;
        logic [15:0] ret, vb;
        logic [7:0]  st;
        int          cycles;
        brk     = (src == 2'b10);
        use_nmi = (src == 2'b01) || (brk && pend);
        ret     = brk ? pc + 16'd1 : pc;
        vb      = use_nmi ? 16'hFFFA : 16'hFFFE;
        st      = {f[5], f[4], 1'b1, brk, f[3], f[2], f[1], f[0]};
        push_exp(pc, 0, 8'h00, 0, sp, f[2], brk ? "R3" : "R2");
        if (!brk) push_exp(pc, 0, 8'h00, 0, sp, f[2], "R2");
        push_exp({8'h01, sp}, 1, ret[15:8], 0, sp, f[2], brk ? "R3" : "R4");
        push_exp({8'h01, sp - 8'd1}, 1, ret[7:0], 0, sp - 8'd1, f[2], brk ? "R3" : "R4");
        push_exp({8'h01, sp - 8'd2}, 1, st, brk && pend, sp - 8'd2, f[2], brk ? "R6" : "R5");
        push_exp(vb, 0, 8'h00, 0, sp - 8'd3, 1'b1, (brk && pend) ? "R9" : "R8");
        push_exp(vb + 16'd1, 0, 8'h00, 0, sp - 8'd3, 1'b1, "R8");

        @(negedge clk);
        src_i = src; pc_i = pc; sp_i = sp;
        {fn, fv, fd, fi, fz, fc} = f;
        nmi_pend_i = pend;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cycles = 1;
        while (!done_o && cycles < 40) begin
            if (poke && cycles == 2) begin
                src_i = 2'b01; pc_i = 16'h4444; sp_i = 8'h44; fi = 1'b1;
                start_i = 1'b1;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            cycles++;
        end
        start_i = 1'b0;
        chk(cycles == (brk ? 7 : 8), "R10", "cycles to done", 64'(cycles), brk ? 64'd7 : 64'd8);
        chk({busy_o, pc_o} == {1'b0, (use_nmi ? 16'h5678 : 16'h1234)}, "R8",
            "busy and pc at done", {47'd0, busy_o, pc_o},
            {48'd0, (use_nmi ? 16'h5678 : 16'h1234)});
        chk(sp_o == sp - 8'd3, "R4", "final sp", 64'(sp_o), 64'(sp - 8'd3));
        chk(iflag_o == 1'b1, "R7", "I flag at done", 64'(iflag_o), 64'd1);
        @(negedge clk);
        chk(done_o == 1'b0, "R10", "done width", 64'(done_o), 64'd0);
        nmi_pend_i = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy_o == 1'b0 && exp_q.size() == 0, "R11", "idle and queue drained after run",
            {31'd0, busy_o, 32'(exp_q.size())}, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk({busy_o, done_o, bus_we_o, bus_rd_o, nmi_ack_o, iflag_o} == 6'b0 &&
            pc_o == 16'd0 && sp_o == 8'd0, "R1", "reset state",
            {32'd0, busy_o, done_o, bus_we_o, bus_rd_o, nmi_ack_o, iflag_o, pc_o, sp_o}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy_o == 1'b0, "R1", "idle after reset", 64'(busy_o), 64'd0);

        // R2 R5 R6 R8: maskable with mixed flags
        run_seq(2'b00, 16'hC0DE, 8'hFD, 6'b101010, 1'b0, 1'b0);
        // R2 R8: non-maskable with I already set
        run_seq(2'b01, 16'h8000, 8'h02, 6'b010101, 1'b0, 1'b0);
        // R3 R4: break across byte boundary with stack wrap
        run_seq(2'b10, 16'h10FF, 8'h00, 6'b000000, 1'b0, 1'b0);
        // R9: break diverted by a pending non-maskable request
        run_seq(2'b10, 16'h2345, 8'h80, 6'b110011, 1'b1, 1'b0);
        // R9: maskable interrupt ignores the pending request
        run_seq(2'b00, 16'h0100, 8'h10, 6'b001100, 1'b1, 1'b0);
        // R11: start during busy is ignored
        run_seq(2'b00, 16'hABCD, 8'hF0, 6'b100001, 1'b0, 1'b1);
        // R2: reserved source code behaves as maskable
        run_seq(2'b11, 16'h7FFF, 8'h01, 6'b011110, 1'b0, 1'b0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule